// File: doc/BRIEF.md
# Mailbox Command Handshake Sequencer

This block is a host-side engine that delivers a single command to a power-management controller. The controller is reached through three mailbox registers on a plain register bus: a response word, a parameter word and a message-identifier word. A local requester presents a message ID and a 32-bit parameter with a valid/ready handshake. The engine waits for any earlier command to finish, then issues the new command. It polls for completion at a fixed interval and with a bounded number of retries. It then hands back the completion code together with the parameter word read back from the controller.

Before it issues anything, the engine polls the response word until it reads non-zero. If the controller stays busy for the whole retry budget, the engine drops the command and flags an error. A non-zero response other than OK only raises a warning. To issue a command, the engine clears the response word, writes the parameter, and finally writes the message ID, which is the write that starts the controller. After issue, the engine polls again, and the first non-zero response ends the wait. If the budget runs out instead, a timeout is flagged. Either way the parameter word is read back as the result.

An optional unit mode takes a frequency in kHz. It sends the value rounded up to whole MHz, and it reports the returned MHz value scaled back to kHz.

Top module: `mbox_cmd_seq`

## Requirements
- R1: After reset, req_ready is 1, done is 0 and bus_req is 0.
- R2: A request is taken only on a cycle with req_valid and req_ready both high. req_ready is high only while the engine is idle, and it stays low from the cycle after acceptance until the done pulse.
- R3: Before any write, the response word (address RSP_ADDR) is read. If it reads 0x00 on all RETRY_MAX+1 reads, done rises with err_drain=1 and status=0x00, and no bus write is made.
- R4: If the pre-issue response is non-zero but not 0x01 (OK), warn_pre is raised with done and the command is still issued.
- R5: A command is issued as exactly three writes, in this order: 0 to RSP_ADDR, then the parameter to PRM_ADDR, then the message ID (zero-extended) to MID_ADDR.
- R6: After issue, the response is polled with at least GAP_CYC = CLK_FREQ_HZ/1e6*POLL_US cycles between reads. The first non-zero read ends polling, and its low 8 bits become status (for example 0x01 OK, 0xFF failed, 0xFE unknown command, 0xFD missing prerequisite, 0xFC controller busy).
- R7: If all RETRY_MAX+1 post-issue reads return 0x00, done rises with timeout=1 and status=0x00, and done_msg carries the message ID.
- R8: After completion or timeout, PRM_ADDR is read once and its value is returned on result. done is a single-cycle pulse, and the flags are high only together with done.
- R9: With req_khz=1, the value written to PRM_ADDR is ceil(req_param/1000), and result is the read-back value times 1000.
- R10: A bus request holds bus_addr, bus_we and bus_wdata steady until bus_ack.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Command request valid |
| req_ready | output | 1 | Engine idle, request can be taken |
| req_msg | input | MSG_W | Message ID of the command |
| req_param | input | DATA_W | Command parameter (kHz when req_khz=1) |
| req_khz | input | 1 | Unit mode: parameter in kHz, result in kHz |
| done | output | 1 | One-cycle completion pulse |
| status | output | STAT_W | Final response code (0x00 on abort or timeout) |
| result | output | DATA_W | Parameter word read back |
| done_msg | output | MSG_W | Message ID of the finished command |
| err_drain | output | 1 | Command aborted, controller stayed busy |
| warn_pre | output | 1 | Pre-issue response was not OK |
| timeout | output | 1 | No completion within the retry budget |
| bus_req | output | 1 | Register bus request |
| bus_we | output | 1 | Write enable |
| bus_addr | output | ADDR_W | Register address |
| bus_wdata | output | DATA_W | Write data |
| bus_ack | input | 1 | Request acknowledge (read data valid) |
| bus_rdata | input | DATA_W | Read data |

## Verification
The assertions assume the bus side is well behaved: bus_ack is a single-cycle pulse, it is given only while bus_req is high, and bus_rdata is valid in that same cycle. The assertions also assume req_valid is raised only when a new command is wanted. The bench's controller model meets these assumptions. It acknowledges exactly one cycle after it sees a request and never acknowledges twice in a row. Only the bench tasks change the response word, and only between commands or through a scheduled completion that follows the message-ID write.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
   localparam logic [7:0] RSP_BUSY = 8'h00;
   localparam logic [7:0] RSP_OK   = 8'h01;

   typedef enum logic [3:0] {
      S_IDLE, S_DRN_RD, S_DRN_GAP, S_CLR, S_PRM, S_MID,
      S_POL_RD, S_POL_GAP, S_BACK, S_DONE
   } seq_st_t;
endpackage

// File: rtl/mbox_gap_timer.sv
module mbox_gap_timer #(
   parameter int GAP_CYC = 1250
) (
   input  logic clk,
   input  logic rst_n,
   input  logic run,
   output logic expired
);
   localparam int CW = (GAP_CYC < 2) ? 1 : $clog2(GAP_CYC);

   generate
      if (GAP_CYC < 1) begin : g_bad
         $error("GAP_CYC must be at least 1");
      end
   endgenerate

   logic [CW-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n || !run) cnt <= '0;
      else if (!expired)  cnt <= cnt + 1'b1;
   end

   assign expired = run && (cnt == CW'(GAP_CYC - 1));
endmodule

// File: rtl/mbox_unit_conv.sv
module mbox_unit_conv #(
   parameter int DATA_W     = 32,
   parameter bit ENABLE_KHZ = 1'b1
) (
   input  logic              khz_mode,
   input  logic [DATA_W-1:0] param_in,
   input  logic [DATA_W-1:0] rd_in,
   output logic [DATA_W-1:0] param_out,
   output logic [DATA_W-1:0] result_out
);
   localparam logic [DATA_W-1:0] K = DATA_W'(1000);

   generate
      if (ENABLE_KHZ) begin : g_khz
         logic [DATA_W-1:0] quo, rem;
         assign quo = param_in / K;
         assign rem = param_in % K;
         assign param_out  = khz_mode ? (quo + DATA_W'(rem != '0)) : param_in;
         assign result_out = khz_mode ? (rd_in * K) : rd_in;
      end else begin : g_raw
         logic unused_mode;
         assign unused_mode = khz_mode;
         assign param_out  = param_in;
         assign result_out = rd_in;
      end
   endgenerate
endmodule

// File: rtl/mbox_cmd_seq.sv
module mbox_cmd_seq
   import mbox_pkg::*;
#(
   parameter int          ADDR_W      = 8,
   parameter int          DATA_W      = 32,
   parameter int          MSG_W       = 8,
   parameter int          STAT_W      = 8,
   parameter int          CLK_FREQ_HZ = 125_000_000,
   parameter int          POLL_US     = 10,
   parameter int          RETRY_MAX   = 200_000,
   parameter bit          ENABLE_KHZ  = 1'b1,
   parameter logic [ADDR_W-1:0] RSP_ADDR = ADDR_W'(8'h08),
   parameter logic [ADDR_W-1:0] PRM_ADDR = ADDR_W'(8'h04),
   parameter logic [ADDR_W-1:0] MID_ADDR = ADDR_W'(8'h00)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [MSG_W-1:0]  req_msg,
   input  logic [DATA_W-1:0] req_param,
   input  logic              req_khz,
   output logic              done,
   output logic [STAT_W-1:0] status,
   output logic [DATA_W-1:0] result,
   output logic [MSG_W-1:0]  done_msg,
   output logic              err_drain,
   output logic              warn_pre,
   output logic              timeout,
   output logic              bus_req,
   output logic              bus_we,
   output logic [ADDR_W-1:0] bus_addr,
   output logic [DATA_W-1:0] bus_wdata,
   input  logic              bus_ack,
   input  logic [DATA_W-1:0] bus_rdata
);
   localparam int GAP_CYC = (CLK_FREQ_HZ / 1_000_000) * POLL_US;
   localparam int TRY_W   = $clog2(RETRY_MAX + 1);

   generate
      if (MSG_W > DATA_W || STAT_W > DATA_W) begin : g_bad_w
         $error("MSG_W and STAT_W must fit in DATA_W");
      end
      if (RETRY_MAX < 1) begin : g_bad_r
         $error("RETRY_MAX must be at least 1");
      end
   endgenerate

   seq_st_t           st;
   logic [MSG_W-1:0]  msg_q;
   logic [DATA_W-1:0] prm_q;
   logic              khz_q;
   logic [TRY_W-1:0]  tries;
   logic              err_q, warn_q, tmo_q;
   logic [STAT_W-1:0] stat_q;
   logic [DATA_W-1:0] res_q;
   logic              gap_done, rsp_zero, out_of_tries;
   logic [DATA_W-1:0] prm_conv, res_conv;

   mbox_gap_timer #(.GAP_CYC(GAP_CYC)) u_gap (
      .clk(clk), .rst_n(rst_n),
      .run(st == S_DRN_GAP || st == S_POL_GAP),
      .expired(gap_done));

   mbox_unit_conv #(.DATA_W(DATA_W), .ENABLE_KHZ(ENABLE_KHZ)) u_conv (
      .khz_mode(st == S_IDLE ? req_khz : khz_q),
      .param_in(req_param), .rd_in(bus_rdata),
      .param_out(prm_conv), .result_out(res_conv));

   assign rsp_zero     = (bus_rdata == '0);
   assign out_of_tries = (tries == TRY_W'(RETRY_MAX));

   always_comb begin
      bus_req   = 1'b0;
      bus_we    = 1'b0;
      bus_addr  = RSP_ADDR;
      bus_wdata = '0;
      unique case (st)
         S_DRN_RD, S_POL_RD: bus_req = 1'b1;
         S_CLR:   begin bus_req = 1'b1; bus_we = 1'b1; end
         S_PRM:   begin bus_req = 1'b1; bus_we = 1'b1; bus_addr = PRM_ADDR;
                        bus_wdata = prm_q; end
         S_MID:   begin bus_req = 1'b1; bus_we = 1'b1; bus_addr = MID_ADDR;
                        bus_wdata = DATA_W'(msg_q); end
         S_BACK:  begin bus_req = 1'b1; bus_addr = PRM_ADDR; end
         default: ;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st     <= S_IDLE;
         msg_q  <= '0;
         prm_q  <= '0;
         khz_q  <= 1'b0;
         tries  <= '0;
         err_q  <= 1'b0;
         warn_q <= 1'b0;
         tmo_q  <= 1'b0;
         stat_q <= '0;
         res_q  <= '0;
      end else begin
         unique case (st)
            S_IDLE: if (req_valid) begin
               msg_q  <= req_msg;
               prm_q  <= prm_conv;
               khz_q  <= req_khz;
               tries  <= '0;
               err_q  <= 1'b0;
               warn_q <= 1'b0;
               tmo_q  <= 1'b0;
               st     <= S_DRN_RD;
            end
            S_DRN_RD: if (bus_ack) begin
               if (!rsp_zero) begin
                  warn_q <= (bus_rdata[STAT_W-1:0] != STAT_W'(RSP_OK)) ||
                            (bus_rdata[DATA_W-1:STAT_W] != '0);
                  st     <= S_CLR;
               end else if (out_of_tries) begin
                  err_q  <= 1'b1;
                  stat_q <= '0;
                  res_q  <= '0;
                  st     <= S_DONE;
               end else begin
                  tries <= tries + 1'b1;
                  st    <= S_DRN_GAP;
               end
            end
            S_DRN_GAP: if (gap_done) st <= S_DRN_RD;
            S_CLR:     if (bus_ack) st <= S_PRM;
            S_PRM:     if (bus_ack) st <= S_MID;
            S_MID: if (bus_ack) begin
               tries <= '0;
               st    <= S_POL_RD;
            end
            S_POL_RD: if (bus_ack) begin
               if (!rsp_zero) begin
                  stat_q <= bus_rdata[STAT_W-1:0];
                  st     <= S_BACK;
               end else if (out_of_tries) begin
                  tmo_q  <= 1'b1;
                  stat_q <= '0;
                  st     <= S_BACK;
               end else begin
                  tries <= tries + 1'b1;
                  st    <= S_POL_GAP;
               end
            end
            S_POL_GAP: if (gap_done) st <= S_POL_RD;
            S_BACK: if (bus_ack) begin
               res_q <= res_conv;
               st    <= S_DONE;
            end
            S_DONE:  st <= S_IDLE;
            default: st <= S_IDLE;
         endcase
      end
   end

   assign req_ready = (st == S_IDLE);
   assign done      = (st == S_DONE);
   assign status    = stat_q;
   assign result    = res_q;
   assign done_msg  = msg_q;
   assign err_drain = done && err_q;
   assign warn_pre  = done && warn_q;
   assign timeout   = done && tmo_q;
endmodule

// File: rtl/mbox_cmd_seq_chk.sv
module mbox_cmd_seq_chk #(
   parameter int          ADDR_W = 8,
   parameter int          DATA_W = 32,
   parameter logic [ADDR_W-1:0] RSP_ADDR = '0,
   parameter logic [ADDR_W-1:0] PRM_ADDR = '0,
   parameter logic [ADDR_W-1:0] MID_ADDR = '0
) (
   input logic              clk,
   input logic              rst_n,
   input logic              req_ready,
   input logic              done,
   input logic              err_drain,
   input logic              warn_pre,
   input logic              timeout,
   input logic              bus_req,
   input logic              bus_we,
   input logic              bus_ack,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_wdata
);
   logic [ADDR_W-1:0] last_wa;

   always_ff @(posedge clk) begin
      if (!rst_n) last_wa <= MID_ADDR;
      else if (bus_req && bus_we && bus_ack) last_wa <= bus_addr;
   end

   // R1 / R2: idle engine makes no bus traffic and no completion
   a_r2_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      req_ready |-> (!bus_req && !done));

   // R5: response clear writes zero
   a_r5_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_we && bus_addr == RSP_ADDR) |-> (bus_wdata == '0));

   // R5: parameter write follows the response clear
   a_r5_prm_after_clr: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_we && bus_addr == PRM_ADDR) |-> (last_wa == RSP_ADDR));

   // R5: message-ID write follows the parameter write
   a_r5_mid_after_prm: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && bus_we && bus_addr == MID_ADDR) |-> (last_wa == PRM_ADDR));

   // R10: request held until acknowledged
   a_r10_bus_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_ack) |=> (bus_req && $stable(bus_addr) &&
                                 $stable(bus_we) && $stable(bus_wdata)));

   // R8: done is a single-cycle pulse
   a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R8: flags appear only with done
   a_r8_flags_with_done: assert property (@(posedge clk) disable iff (!rst_n)
      (err_drain || warn_pre || timeout) |-> done);

   // R3: an aborted command carries neither warning nor timeout
   a_r3_abort_alone: assert property (@(posedge clk) disable iff (!rst_n)
      err_drain |-> (!warn_pre && !timeout));
endmodule

bind mbox_cmd_seq mbox_cmd_seq_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W),
   .RSP_ADDR(RSP_ADDR), .PRM_ADDR(PRM_ADDR), .MID_ADDR(MID_ADDR)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .done(done),
   .err_drain(err_drain), .warn_pre(warn_pre), .timeout(timeout),
   .bus_req(bus_req), .bus_we(bus_we), .bus_ack(bus_ack),
   .bus_addr(bus_addr), .bus_wdata(bus_wdata)
);

// File: tb/tb_mbox_cmd_seq.sv
`timescale 1ns/1ps
module tb_mbox_cmd_seq;
   localparam int AW = 8, DW = 32, MW = 8, SW = 8;
   localparam int CLKHZ = 1_000_000, PUS = 3, RMAX = 5;
   localparam int GAP = (CLKHZ / 1_000_000) * PUS;
   localparam logic [7:0] A_RSP = 8'h08, A_PRM = 8'h04, A_MID = 8'h00;

   logic clk = 0, rst_n = 0;
   always #4 clk = ~clk;

   logic req_valid = 0, req_ready, req_khz = 0;
   logic [MW-1:0] req_msg = '0;
   logic [DW-1:0] req_param = '0;
   logic done, err_drain, warn_pre, timeout;
   logic [SW-1:0] status;
   logic [DW-1:0] result;
   logic [MW-1:0] done_msg;
   logic bus_req, bus_we, bus_ack;
   logic [AW-1:0] bus_addr;
   logic [DW-1:0] bus_wdata, bus_rdata;

   mbox_cmd_seq #(.ADDR_W(AW), .DATA_W(DW), .MSG_W(MW), .STAT_W(SW),
      .CLK_FREQ_HZ(CLKHZ), .POLL_US(PUS), .RETRY_MAX(RMAX),
      .RSP_ADDR(A_RSP), .PRM_ADDR(A_PRM), .MID_ADDR(A_MID)) dut (.*);

   // controller model
   logic [DW-1:0] rsp_reg, prm_reg;
   logic          pre_set = 0;
   logic [DW-1:0] pre_val = '0;
   logic          cm_arm = 0;
   int            cm_delay = 0;
   logic [DW-1:0] cm_status = '0, cm_ret = '0;
   logic          pend;
   int            pend_cnt, cyc, last_rd, min_gap, wcnt, rcnt;
   logic [AW-1:0] wlog_a [0:63];
   logic [DW-1:0] wlog_d [0:63];

   always @(posedge clk) begin
      if (!rst_n) begin
         bus_ack <= 0; bus_rdata <= '0; rsp_reg <= 32'h1; prm_reg <= '0;
         pend <= 0; pend_cnt <= 0; cyc <= 0; last_rd <= -1000;
         min_gap <= 1000; wcnt <= 0; rcnt <= 0;
      end else begin
         cyc <= cyc + 1;
         bus_ack <= 0;
         if (pre_set) begin
            rsp_reg <= pre_val; min_gap <= 1000; last_rd <= -1000;
         end
         if (pend) begin
            if (pend_cnt == 0) begin
               rsp_reg <= cm_status; prm_reg <= cm_ret; pend <= 0;
            end else pend_cnt <= pend_cnt - 1;
         end
         if (bus_req && !bus_ack) begin
            bus_ack <= 1;
            if (bus_we) begin
               wlog_a[wcnt[5:0]] <= bus_addr;
               wlog_d[wcnt[5:0]] <= bus_wdata;
               wcnt <= wcnt + 1;
               if (bus_addr == A_RSP) rsp_reg <= bus_wdata;
               if (bus_addr == A_PRM) prm_reg <= bus_wdata;
               if (bus_addr == A_MID && cm_arm) begin
                  pend <= 1; pend_cnt <= cm_delay;
               end
            end else if (bus_addr == A_RSP) begin
               bus_rdata <= rsp_reg;
               rcnt <= rcnt + 1;
               last_rd <= cyc;
               if (cyc - last_rd < min_gap) min_gap <= cyc - last_rd;
            end else if (bus_addr == A_PRM) bus_rdata <= prm_reg;
            else bus_rdata <= '0;
         end
      end
   end

   int  total = 0, bad = 0;
   bit  finished = 0;

   task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic preset(input logic [DW-1:0] v);
      @(negedge clk); pre_val = v; pre_set = 1;
      @(negedge clk); pre_set = 0;
   endtask

   int wbase, rbase;

   task automatic run_cmd(input logic [MW-1:0] m, input logic [DW-1:0] p, input logic k);
      wbase = wcnt; rbase = rcnt;
      @(negedge clk);
      req_msg = m; req_param = p; req_khz = k; req_valid = 1;
      @(negedge clk);
      req_valid = 0;
      chk("R2 ready low while busy", {31'b0, req_ready}, 32'h0);
      for (int i = 0; i < 3000 && !done; i++) @(negedge clk);
      if (!done) chk("R8 done never seen", 32'h0, 32'h1);
   endtask

   task automatic t_reset;
      chk("R1 ready after reset", {31'b0, req_ready}, 32'h1);
      chk("R1 done after reset", {31'b0, done}, 32'h0);
      chk("R1 bus idle after reset", {31'b0, bus_req}, 32'h0);
   endtask

   task automatic t_ok;
      preset(32'h1); cm_arm = 1; cm_delay = 12; cm_status = 32'h01; cm_ret = 32'h0456;
      run_cmd(8'h04, 32'h1234, 0);
      chk("R6 status OK", {24'b0, status}, 32'h01);
      chk("R8 result readback", result, 32'h0456);
      chk("R8 done_msg", {24'b0, done_msg}, 32'h04);
      chk("R4 no warning", {31'b0, warn_pre}, 32'h0);
      chk("R5 write count", wcnt - wbase, 3);
      chk("R5 first write addr", {24'b0, wlog_a[wbase[5:0]]}, {24'b0, A_RSP});
      chk("R5 first write data", wlog_d[wbase[5:0]], 32'h0);
      chk("R5 second write addr", {24'b0, wlog_a[6'(wbase + 1)]}, {24'b0, A_PRM});
      chk("R5 second write data", wlog_d[6'(wbase + 1)], 32'h1234);
      chk("R5 third write addr", {24'b0, wlog_a[6'(wbase + 2)]}, {24'b0, A_MID});
      chk("R5 third write data", wlog_d[6'(wbase + 2)], 32'h04);
      chk("R6 several polls", {31'b0, (rcnt - rbase) >= 3}, 32'h1);
      chk("R6 poll spacing", {31'b0, min_gap >= GAP}, 32'h1);
      @(negedge clk);
      chk("R8 done single cycle", {31'b0, done}, 32'h0);
      chk("R2 ready after done", {31'b0, req_ready}, 32'h1);
   endtask

   task automatic t_fail_code;
      preset(32'h1); cm_arm = 1; cm_delay = 0; cm_status = 32'hFE; cm_ret = 32'h77;
      run_cmd(8'h2A, 32'h9, 0);
      chk("R6 unknown-command code", {24'b0, status}, 32'hFE);
      chk("R7 no timeout on code", {31'b0, timeout}, 32'h0);
   endtask

   task automatic t_drain_abort;
      preset(32'h0); cm_arm = 0;
      run_cmd(8'h10, 32'hABCD, 0);
      chk("R3 err_drain", {31'b0, err_drain}, 32'h1);
      chk("R3 status zero", {24'b0, status}, 32'h0);
      chk("R3 no writes", wcnt - wbase, 0);
      chk("R3 read count", rcnt - rbase, RMAX + 1);
   endtask

   task automatic t_warn;
      preset(32'hFD); cm_arm = 1; cm_delay = 2; cm_status = 32'h01; cm_ret = 32'h5;
      run_cmd(8'h07, 32'h20, 0);
      chk("R4 warn_pre", {31'b0, warn_pre}, 32'h1);
      chk("R4 still issued", wcnt - wbase, 3);
      chk("R4 status", {24'b0, status}, 32'h01);
   endtask

   task automatic t_timeout;
      preset(32'h1); cm_arm = 0;
      run_cmd(8'h11, 32'h3C, 0);
      chk("R7 timeout flag", {31'b0, timeout}, 32'h1);
      chk("R7 status zero", {24'b0, status}, 32'h0);
      chk("R7 done_msg", {24'b0, done_msg}, 32'h11);
      chk("R7 poll reads", rcnt - rbase, RMAX + 2);
      chk("R8 readback on timeout", result, 32'h3C);
   endtask

   task automatic t_khz;
      preset(32'h1); cm_arm = 1; cm_delay = 1; cm_status = 32'h01; cm_ret = 32'd1600;
      run_cmd(8'h04, 32'd1500001, 1);
      chk("R9 rounded-up MHz", wlog_d[6'(wbase + 1)], 32'd1501);
      chk("R9 result in kHz", result, 32'd1600000);
      preset(32'h1); cm_ret = 32'd2;
      run_cmd(8'h06, 32'd2000, 1);
      chk("R9 exact multiple", wlog_d[6'(wbase + 1)], 32'd2);
      chk("R9 exact result", result, 32'd2000);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_ok();
      t_fail_code();
      t_drain_abort();
      t_warn();
      t_timeout();
      t_khz();
      if (!finished) begin
         finished = 1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         total++; bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule